// File: doc/BRIEF.md
# Three-Lane 7:1 Serializing Transmitter

This block turns a 21-bit parallel word into three serial lanes of seven bits each. It also sends a forwarded clock that runs at the word rate. Everything runs on one bit clock at seven times the word rate. An internal modulo-7 slot counter marks the frame, so no separate word strobe is needed.

On the edge that closes each frame, the block samples the whole input word into a holding register. On that same edge, the word held from the previous frame is parallel-loaded into the three lane shift registers. Each lane then shifts its seven bits out, lowest-numbered bit first, with no idle slot between frames. The forwarded clock is high for the first four slots of each frame and low for the last three.

An active-low shutdown input clears every register at once and holds all outputs low, including the output-enable flag. After release, output enable rises on the first bit-clock edge and the slot counter starts at slot 0. The lanes carry zeros for two frames. The first word sampled after release appears in the third frame.

Top module: `tx7_serializer`

## Requirements
- R1: All 21 input bits are sampled together on the bit-clock edge that ends slot 6 of a frame. The word sampled at the end of frame f is sent during frame f+2, counting frame 0 as the first frame after release.
- R2: Lane 0 (ser_o[0]) carries din[6:0], lane 1 carries din[13:7] and lane 2 carries din[20:14]. In slot s (0..6) each lane outputs bit s of its slice, so the lowest-numbered bit goes first.
- R3: The slot counter counts 0,1,...,6 and then wraps to 0. Each frame is exactly seven bit-clock cycles long.
- R4: While enabled, fclk_o is high in slots 0 to 3 and low in slots 4 to 6. It therefore has one period per frame and rises only at the start of slot 0.
- R5: While shdn_n is low, ser_o, fclk_o and oe_o are all 0. They go low as soon as shdn_n falls, without waiting for a clock edge.
- R6: Shutdown clears the holding register, the shift registers and the slot counter. After release, the lanes output zeros for frames 0 and 1, even if data was being sent before the shutdown.
- R7: There are no gaps between frames. Slot 6 of one word is followed directly by slot 0 of the next word on every lane.
- R8: Changes on din at any time other than the sampling edge have no effect on what is sent.
- R9: oe_o rises on the first bit-clock edge after shdn_n is released. Frame 0, slot 0 begins on that same edge, and oe_o stays high until the next shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the word rate |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| din | input | 21 | Parallel word to send |
| ser_o | output | 3 | Serial lane outputs, one bit per lane |
| fclk_o | output | 1 | Forwarded word-rate clock pattern |
| oe_o | output | 1 | Output enable, high while running |

## Verification
A slot counter that skips or repeats a value shows up within one frame at two points. The 4/3 high/low pattern of fclk_o breaks, and every lane goes out of step with the bench's slot index. A fault in the holding register, the lane mapping or the load timing puts a wrong bit on a lane within two frames of the affected word. The stimulus uses patterns whose bits differ by position and by lane, so swapped or shifted bits are caught. A register that survives shutdown shows up as nonzero lane data in the first two frames after release.

// File: rtl/tx7_pkg.sv
package tx7_pkg;

  // Forwarded clock level for a given slot: high for the first hi_slots slots.
  function automatic logic fwd_level(input int unsigned slot, input int unsigned hi_slots);
    return (slot < hi_slots);
  endfunction

  // Next slot index with wrap after the last slot.
  function automatic int unsigned next_slot(input int unsigned slot, input int unsigned last);
    return (slot >= last) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/tx7_phase.sv
module tx7_phase #(
  parameter int unsigned LANE_W = 7,
  parameter int unsigned PW     = 3
) (
  input  logic          clk,
  input  logic          shdn_n,
  output logic          run,
  output logic [PW-1:0] phase,
  output logic          frame_end
);
  import tx7_pkg::*;

  localparam int unsigned LAST = LANE_W - 1;

  logic          run_q;
  logic [PW-1:0] phase_q;

  assign run       = run_q;
  assign phase     = phase_q;
  assign frame_end = run_q && (phase_q == PW'(LAST));

  always_ff @(posedge clk or negedge shdn_n) begin
    if (!shdn_n) begin
      run_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) phase_q <= PW'(next_slot(32'(phase_q), LAST));
    end
  end

endmodule

// File: rtl/tx7_capture.sv
module tx7_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk,
  input  logic              shdn_n,
  input  logic              take,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge shdn_n) begin
    if (!shdn_n)   word <= '0;
    else if (take) word <= din;
  end
endmodule

// File: rtl/tx7_lane.sv
module tx7_lane #(
  parameter int unsigned LANE_W = 7
) (
  input  logic              clk,
  input  logic              shdn_n,
  input  logic              load,
  input  logic [LANE_W-1:0] par,
  output logic              ser
);
  logic [LANE_W-1:0] sh_q;

  assign ser = sh_q[0];

  always_ff @(posedge clk or negedge shdn_n) begin
    if (!shdn_n)   sh_q <= '0;
    else if (load) sh_q <= par;
    else           sh_q <= {1'b0, sh_q[LANE_W-1:1]};
  end
endmodule

// File: rtl/tx7_serializer.sv
module tx7_serializer #(
  parameter int unsigned LANE_W    = 7,
  parameter int unsigned LANES     = 3,
  parameter int unsigned FCLK_HIGH = 4
) (
  input  logic                    clk,
  input  logic                    shdn_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES-1:0]        ser_o,
  output logic                    fclk_o,
  output logic                    oe_o
);
  import tx7_pkg::*;

  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned PW     = (LANE_W > 1) ? $clog2(LANE_W) : 1;

  logic              run;
  logic [PW-1:0]     phase;
  logic              frame_end;
  logic [WORD_W-1:0] held_word;
  logic [LANES-1:0]  lane_raw;

  tx7_phase #(.LANE_W(LANE_W), .PW(PW)) u_phase (
    .clk(clk), .shdn_n(shdn_n), .run(run), .phase(phase), .frame_end(frame_end)
  );

  tx7_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .shdn_n(shdn_n), .take(frame_end), .din(din), .word(held_word)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tx7_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .shdn_n(shdn_n), .load(frame_end),
      .par(held_word[l*LANE_W +: LANE_W]), .ser(lane_raw[l])
    );
  end

  assign ser_o  = (shdn_n && run) ? lane_raw : '0;
  assign fclk_o = shdn_n && run && fwd_level(32'(phase), FCLK_HIGH);
  assign oe_o   = shdn_n && run;

endmodule

// File: rtl/tx7_serializer_chk.sv
module tx7_serializer_chk #(
  parameter int unsigned LANE_W = 7,
  parameter int unsigned LANES  = 3,
  parameter int unsigned PW     = 3
) (
  input logic             clk,
  input logic             shdn_n,
  input logic [PW-1:0]    phase,
  input logic             frame_end,
  input logic [LANES-1:0] ser_o,
  input logic             fclk_o,
  input logic             oe_o
);
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!shdn_n)
    phase <= PW'(LANE_W - 1));

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!shdn_n)
    frame_end |=> (phase == '0));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!shdn_n)
    (oe_o && !frame_end) |=> (phase == $past(phase) + 1'b1));

  // R4
  fclk_rise_chk: assert property (@(posedge clk) disable iff (!shdn_n)
    $rose(fclk_o) |-> (phase == '0));

  // R5
  shutdown_quiet_chk: assert property (@(posedge clk)
    !shdn_n |-> (ser_o == '0 && !fclk_o && !oe_o));

  // R9
  oe_hold_chk: assert property (@(posedge clk) disable iff (!shdn_n)
    oe_o |=> oe_o);
endmodule

bind tx7_serializer tx7_serializer_chk #(.LANE_W(LANE_W), .LANES(LANES), .PW(PW)) u_chk (
  .clk(clk), .shdn_n(shdn_n), .phase(phase), .frame_end(frame_end),
  .ser_o(ser_o), .fclk_o(fclk_o), .oe_o(oe_o)
);

// File: tb/tb_tx7_serializer.sv
module tb_tx7_serializer;
  logic        clk = 1'b0;
  logic        shdn_n = 1'b0;
  logic [20:0] din = '0;
  logic [2:0]  ser_o;
  logic        fclk_o;
  logic        oe_o;

  int checks = 0;
  int errors = 0;

  logic [20:0] stream [0:15];

  always #5 clk = ~clk;

  tx7_serializer dut (
    .clk(clk), .shdn_n(shdn_n), .din(din),
    .ser_o(ser_o), .fclk_o(fclk_o), .oe_o(oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Release shutdown at a falling edge; returns at the sample point of frame 0 slot 0.
  task automatic release_sd();
    shdn_n = 1'b1;
    step();
    chk("R9 oe after release", 32'(oe_o), 1);
  endtask

  // Send n words from stream; check every slot, including two trailing frames.
  task automatic run_stream(input int n, input bit glitch);
    for (int f = 0; f < n + 2; f++) begin
      logic [20:0] cur;
      logic [20:0] exp_w;
      cur   = (f < n) ? stream[f] : 21'h0;
      exp_w = (f >= 2) ? stream[f-2] : 21'h0;
      for (int s = 0; s < 7; s++) begin
        if (glitch && s >= 1 && s <= 5) din = ~cur ^ 21'(s * 37);
        else                            din = cur;
        for (int l = 0; l < 3; l++)
          chk("R2 R7 R1 lane bit", 32'(ser_o[l]), 32'(exp_w[l*7 + s]));
        chk("R4 R3 fclk pattern", 32'(fclk_o), (s < 4) ? 1 : 0);
        chk("R9 oe held", 32'(oe_o), 1);
        step();
      end
    end
  endtask

  task automatic t_reset();
    step();
    chk("R5 reset lanes", 32'(ser_o), 0);
    chk("R5 reset fclk", 32'(fclk_o), 0);
    chk("R5 reset oe", 32'(oe_o), 0);
  endtask

  task automatic t_walking();
    release_sd();
    for (int i = 0; i < 12; i++) stream[i] = 21'(1) << (i * 2 % 21);
    stream[12] = 21'h1FFFFF;
    stream[13] = 21'h0;
    run_stream(14, 1'b0);
  endtask

  task automatic t_patterns();
    stream[0] = 21'h155555; stream[1] = 21'h0AAAAA;
    stream[2] = 21'h00007F; stream[3] = 21'h003F80;
    stream[4] = 21'h1FC000; stream[5] = 21'h123456;
    run_stream(6, 1'b0);
  endtask

  task automatic t_glitch();
    // R8: din toggles between sampling edges
    stream[0] = 21'h0F0F0F; stream[1] = 21'h1A2B3C; stream[2] = 21'h054321;
    run_stream(3, 1'b1);
  endtask

  task automatic t_shutdown_mid();
    stream[0] = 21'h1FFFFF; stream[1] = 21'h1FFFFF;
    run_stream(1, 1'b0);
    din = 21'h1FFFFF;
    for (int s = 0; s < 10; s++) step();
    shdn_n = 1'b0;
    #1;
    chk("R5 async lanes", 32'(ser_o), 0);
    chk("R5 async fclk", 32'(fclk_o), 0);
    chk("R5 async oe", 32'(oe_o), 0);
    step(); step();
    chk("R5 held lanes", 32'(ser_o), 0);
    chk("R5 held oe", 32'(oe_o), 0);
    // R6: cleared state gives two zero frames despite din being all ones
    release_sd();
    stream[0] = 21'h1FFFFF; stream[1] = 21'h0ABCDE;
    run_stream(2, 1'b0);
  endtask

  initial begin
    t_reset();
    t_walking();
    t_patterns();
    t_glitch();
    t_shutdown_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule